// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block receives stereo audio over a three-wire serial link in which it is the slave: an external source drives the bit clock, the word-select (channel) line and the data line. All three lines are oversampled on a faster system clock. Each bit is taken when a rising bit-clock edge is seen. The block rebuilds one left and one right sample per frame and presents the two together on parallel outputs, with a single-cycle strobe.

A two-bit selector picks the framing. The first framing is standard I2S: the word starts one bit clock after the channel change and is sent MSB first. The other three framings are right-aligned at 16, 20 or 24 bits. In those, the word's last bit sits in the final slot before the next channel change, so the word is only known to be complete when that change arrives. Every sample leaves the block as a 24-bit value. A word that arrives with fewer bits than the selected framing needs is reported with an error pulse and is not delivered.

Top module: `serial_audio_rx`

## Requirements
- R1: The selector `fmt_sel_i` chooses the framing: 2'b00 selects I2S, 2'b01 selects right-aligned 16-bit, 2'b10 selects right-aligned 20-bit and 2'b11 selects right-aligned 24-bit.
- R2: In I2S framing, a word runs from the second rising bit-clock edge after a channel change up to and including the first rising edge after the following change, MSB first. The first 24 bits are kept, bits beyond the 24th are ignored, and a shorter word is left-aligned in the 24-bit output with zeros below its LSB.
- R3: In a right-aligned framing of width W (16, 20 or 24), the last W bits sampled before a channel change form the word, with its LSB in the last slot. Earlier bits of the same half are ignored. The word is sign-extended from bit W-1 to 24 bits.
- R4: Word select low carries the left channel and high carries the right channel. The right-word boundary is the rising bit-clock edge at which word select is first seen low again. Three system-clock edges after the first edge that samples that rising bit-clock level, `left_o` and `right_o` are loaded with the frame's pair and `pair_valid_o` is high for exactly one cycle.
- R5: A word with fewer bits than required (8 for I2S, W for right-aligned) raises `frame_err_o` for one cycle, at the point where a complete word would be accepted. A short word is never presented, and an error pulse never coincides with `pair_valid_o`.
- R6: After reset, the word in progress at the first channel change is discarded, and a right word is presented only together with a left word completed earlier in the same frame.
- R7: While reset is asserted, `left_o` and `right_o` are zero and both strobes are low.
- R8: `left_o` and `right_o` hold their values in every cycle in which `pair_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial lines |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_sel_i | input | 2 | Framing selector (encoding in R1) |
| bit_clk_i | input | 1 | Serial bit clock from the source |
| frame_sel_i | input | 1 | Word select: low = left, high = right |
| ser_data_i | input | 1 | Serial data, changing on falling bit-clock edges |
| left_o | output | 24 | Last presented left sample |
| right_o | output | 24 | Last presented right sample |
| pair_valid_o | output | 1 | One-cycle strobe when a new pair is loaded |
| frame_err_o | output | 1 | One-cycle strobe for a word that is too short |

## Verification
The bound checker checks four things on every cycle: that the pair strobe and the error strobe are single-cycle pulses that never coincide, that the sample outputs stay frozen whenever no pair is strobed, and that right-aligned 16- and 20-bit samples come out properly sign-extended. Only the bench scenarios can show the bit order and alignment of each framing. The same goes for dropping I2S bits past the 24th, zero padding of short I2S words, and discarding the first partial word after reset. They also show the exact three-edge latency and which short words produce error pulses. A behavioural model predicts these from the sent bit streams and compares them in every cycle.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int unsigned SAMPLE_W      = 24;
    localparam int unsigned SLOT_CNT_W    = 6;
    localparam int unsigned I2S_MIN_BITS  = 8;
    localparam int unsigned SYNC_STAGES   = 2;
    localparam int unsigned RJ_BASE_W     = 12;
    localparam int unsigned RJ_STEP_W     = 4;

    // Framing selector codes; the numeric value also sets the right-aligned width.
    typedef enum logic [1:0] {
        FMT_I2S  = 2'b00,
        FMT_RJ16 = 2'b01,
        FMT_RJ20 = 2'b10,
        FMT_RJ24 = 2'b11
    } fmt_e;

    // Right-aligned word width in bits for a selector code (16, 20, 24).
    function automatic int rj_width(fmt_e f);
        return int'(RJ_BASE_W) + int'(RJ_STEP_W) * int'(f);
    endfunction

endpackage

// File: rtl/sar_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous lines.
module sar_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [WIDTH-1:0] flop_q;
        if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) flop_q <= '0;
                else         flop_q <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) flop_q <= '0;
                else         flop_q <= g_stage[s-1].flop_q;
            end
        end
    end

    assign sync_o = g_stage[STAGES-1].flop_q;

endmodule

// File: rtl/sar_edge.sv
// Finds rising bit-clock edges in the system-clock domain and forwards the
// word-select and data levels that belong to each edge.
module sar_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic bclk_s_i,
    input  logic ws_s_i,
    input  logic sd_s_i,
    output logic rise_o,
    output logic ws_o,
    output logic sd_o
);

    logic bclk_prev_d, bclk_prev_q;

    always_comb begin
        bclk_prev_d = bclk_s_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bclk_prev_q <= 1'b0;
        else         bclk_prev_q <= bclk_prev_d;
    end

    // Word select and data travel through the same number of stages as the
    // bit clock, so their levels at the detected edge are the ones the
    // source held stable across its rising edge.
    assign rise_o = bclk_s_i & ~bclk_prev_q;
    assign ws_o   = ws_s_i;
    assign sd_o   = sd_s_i;

endmodule

// File: rtl/sar_word_asm.sv
// Accumulates serial bits into words and announces each word at its boundary.
module sar_word_asm
    import sar_pkg::*;
#(
    parameter int unsigned SMP_W   = SAMPLE_W,
    parameter int unsigned CNT_W   = SLOT_CNT_W,
    parameter int unsigned MIN_I2S = I2S_MIN_BITS
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  fmt_e             fmt_i,
    input  logic             rise_i,
    input  logic             ws_i,
    input  logic             sd_i,
    output logic             fin_o,
    output logic             fin_right_o,
    output logic             fin_short_o,
    output logic [SMP_W-1:0] fin_word_o
);

    localparam int unsigned IDX_W = $clog2(SMP_W);

    typedef struct packed {
        logic [SMP_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
        logic             ws_last;
        logic             armed;
    } asm_st_t;

    asm_st_t st_d, st_q;

    logic             is_i2s;
    logic [SMP_W-1:0] rj_shift;
    logic [SMP_W-1:0] i2s_place;
    logic [SMP_W-1:0] absorbed;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] fin_cnt;
    logic [IDX_W-1:0] place_idx;

    // Sign-extend the low w bits of a to the full sample width.
    function automatic logic [SMP_W-1:0] sign_fill(logic [SMP_W-1:0] a, int w);
        int sh;
        sh = int'(SMP_W) - w;
        return SMP_W'($signed(a << sh) >>> sh);
    endfunction

    function automatic logic [CNT_W-1:0] need_bits(fmt_e f);
        if (f == FMT_I2S) return CNT_W'(MIN_I2S);
        return CNT_W'(rj_width(f));
    endfunction

    always_comb begin
        st_d        = st_q;
        fin_o       = 1'b0;
        fin_right_o = st_q.ws_last;
        fin_word_o  = '0;
        fin_cnt     = '0;

        is_i2s    = (fmt_i == FMT_I2S);
        rj_shift  = {st_q.acc[SMP_W-2:0], sd_i};
        place_idx = IDX_W'(SMP_W - 1) - IDX_W'(st_q.cnt);
        i2s_place = st_q.acc;
        if (st_q.cnt < CNT_W'(SMP_W)) begin
            i2s_place[place_idx] = sd_i;
        end
        absorbed = is_i2s ? i2s_place : rj_shift;
        cnt_inc  = (st_q.cnt == '1) ? st_q.cnt : st_q.cnt + 1'b1;

        if (rise_i) begin
            if (ws_i == st_q.ws_last) begin
                st_d.acc = absorbed;
                st_d.cnt = cnt_inc;
            end else begin
                fin_o        = st_q.armed;
                st_d.armed   = 1'b1;
                st_d.ws_last = ws_i;
                if (is_i2s) begin
                    // The bit at the channel change still belongs to the old word.
                    fin_word_o = absorbed;
                    fin_cnt    = cnt_inc;
                    st_d.acc   = '0;
                    st_d.cnt   = '0;
                end else begin
                    // The old word ended one slot ago; this bit opens the next one.
                    fin_word_o = sign_fill(st_q.acc, rj_width(fmt_i));
                    fin_cnt    = st_q.cnt;
                    st_d.acc   = {{(SMP_W-1){1'b0}}, sd_i};
                    st_d.cnt   = CNT_W'(1);
                end
            end
        end

        fin_short_o = (fin_cnt < need_bits(fmt_i));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

endmodule

// File: rtl/serial_audio_rx.sv
// Slave-mode stereo serial audio receiver, top level.
module serial_audio_rx
    import sar_pkg::*;
#(
    parameter int unsigned SMP_W  = SAMPLE_W,
    parameter int unsigned CNT_W  = SLOT_CNT_W,
    parameter int unsigned STAGES = SYNC_STAGES
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [1:0]       fmt_sel_i,
    input  logic             bit_clk_i,
    input  logic             frame_sel_i,
    input  logic             ser_data_i,
    output logic [SMP_W-1:0] left_o,
    output logic [SMP_W-1:0] right_o,
    output logic             pair_valid_o,
    output logic             frame_err_o
);

    localparam int unsigned LINES = 3;

    typedef struct packed {
        logic [SMP_W-1:0] left_hold;
        logic             left_have;
        logic [SMP_W-1:0] left;
        logic [SMP_W-1:0] right;
        logic             valid;
        logic             err;
    } pair_st_t;

    fmt_e             fmt;
    logic [LINES-1:0] lines_s;
    logic             rise, ws_at_rise, sd_at_rise;
    logic             fin, fin_right, fin_short;
    logic [SMP_W-1:0] fin_word;
    pair_st_t         pr_d, pr_q;

    assign fmt = fmt_e'(fmt_sel_i);

    sar_sync #(
        .WIDTH  (LINES),
        .STAGES (STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({bit_clk_i, frame_sel_i, ser_data_i}),
        .sync_o  (lines_s)
    );

    sar_edge u_edge (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .bclk_s_i (lines_s[2]),
        .ws_s_i   (lines_s[1]),
        .sd_s_i   (lines_s[0]),
        .rise_o   (rise),
        .ws_o     (ws_at_rise),
        .sd_o     (sd_at_rise)
    );

    sar_word_asm #(
        .SMP_W (SMP_W),
        .CNT_W (CNT_W)
    ) u_asm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .fmt_i       (fmt),
        .rise_i      (rise),
        .ws_i        (ws_at_rise),
        .sd_i        (sd_at_rise),
        .fin_o       (fin),
        .fin_right_o (fin_right),
        .fin_short_o (fin_short),
        .fin_word_o  (fin_word)
    );

    // Pairing: a left word waits in left_hold until its right partner arrives.
    always_comb begin
        pr_d       = pr_q;
        pr_d.valid = 1'b0;
        pr_d.err   = 1'b0;
        if (fin) begin
            if (fin_short) begin
                pr_d.err       = 1'b1;
                pr_d.left_have = 1'b0;
            end else if (!fin_right) begin
                pr_d.left_hold = fin_word;
                pr_d.left_have = 1'b1;
            end else begin
                if (pr_q.left_have) begin
                    pr_d.valid = 1'b1;
                    pr_d.left  = pr_q.left_hold;
                    pr_d.right = fin_word;
                end
                pr_d.left_have = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pr_q <= '0;
        else         pr_q <= pr_d;
    end

    assign left_o       = pr_q.left;
    assign right_o      = pr_q.right;
    assign pair_valid_o = pr_q.valid;
    assign frame_err_o  = pr_q.err;

endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
    parameter int unsigned SMP_W = 24
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [1:0]       fmt_sel_i,
    input logic [SMP_W-1:0] left_o,
    input logic [SMP_W-1:0] right_o,
    input logic             pair_valid_o,
    input logic             frame_err_o
);

    AST_PAIR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pair_valid_o |=> !pair_valid_o);                                   // R4

    AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_err_o |=> !frame_err_o);                                     // R5

    AST_ERR_NOT_WITH_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(pair_valid_o && frame_err_o));                                   // R5

    AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pair_valid_o |-> ($stable(left_o) && $stable(right_o)));          // R8

    AST_RJ16_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pair_valid_o && fmt_sel_i == 2'b01) |->
            (left_o[SMP_W-1:15] == {(SMP_W-15){left_o[15]}} &&
             right_o[SMP_W-1:15] == {(SMP_W-15){right_o[15]}}));           // R3

    AST_RJ20_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pair_valid_o && fmt_sel_i == 2'b10) |->
            (left_o[SMP_W-1:19] == {(SMP_W-19){left_o[19]}} &&
             right_o[SMP_W-1:19] == {(SMP_W-19){right_o[19]}}));           // R3

endmodule

bind serial_audio_rx serial_audio_rx_chk #(.SMP_W(SMP_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fmt_sel_i    (fmt_sel_i),
    .left_o       (left_o),
    .right_o      (right_o),
    .pair_valid_o (pair_valid_o),
    .frame_err_o  (frame_err_o)
);

// File: tb/serial_audio_rx_test.sv
module serial_audio_rx_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;      // system clocks per bit-clock phase
    localparam int LATENCY    = 3;      // edges from driven rise to output
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic        bclk = 1'b0, wsel = 1'b0, sdat = 1'b0;
    logic [23:0] left, right;
    logic        valid, err;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_audio_rx uut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .fmt_sel_i    (fmt),
        .bit_clk_i    (bclk),
        .frame_sel_i  (wsel),
        .ser_data_i   (sdat),
        .left_o       (left),
        .right_o      (right),
        .pair_valid_o (valid),
        .frame_err_o  (err)
    );

    typedef struct {
        int          cyc;
        bit          is_err;
        logic [23:0] l;
        logic [23:0] r;
        string       tag;
    } exp_t;

    exp_t        expq[$];
    int          cyc = 0;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          checking = 1'b0;
    logic [23:0] held_l = '0, held_r = '0;

    always @(posedge clk) cyc <= cyc + 1;

    // Per-cycle comparison against the behavioural expectation.
    exp_t  cur_e;
    bit    ev, exp_v, exp_e;
    string tg;
    always @(negedge clk) begin
        if (checking) begin
            while (expq.size() > 0 && expq[0].cyc < cyc) begin
                cur_e = expq.pop_front();
                n_cmp++; n_bad++;
                $display("FAIL %s: expected event at cycle %0d missing (actual none, expected strobe)", cur_e.tag, cur_e.cyc);
            end
            ev = (expq.size() > 0) && (expq[0].cyc == cyc);
            exp_v = 1'b0; exp_e = 1'b0; tg = "R4 R5 R6 R8 idle";
            if (ev) begin
                cur_e = expq.pop_front();
                exp_v = !cur_e.is_err;
                exp_e = cur_e.is_err;
                tg    = cur_e.tag;
                if (exp_v) begin held_l = cur_e.l; held_r = cur_e.r; end
            end
            n_cmp++;
            if (valid !== exp_v || err !== exp_e || left !== held_l || right !== held_r) begin
                n_bad++;
                $display("FAIL %s cyc %0d: actual valid=%b err=%b left=%h right=%h expected valid=%b err=%b left=%h right=%h",
                         tg, cyc, valid, err, left, right, exp_v, exp_e, held_l, held_r);
            end
        end
    end

    task automatic apply_reset(input logic [1:0] f);
        checking = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b0; bclk = 1'b0; wsel = 1'b0; sdat = 1'b0; fmt = f;
        expq.delete(); held_l = '0; held_r = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (left !== 24'h0 || right !== 24'h0 || valid !== 1'b0 || err !== 1'b0) begin
            n_bad++;
            $display("FAIL R7 reset: actual left=%h right=%h valid=%b err=%b expected 0 0 0 0",
                     left, right, valid, err);
        end
        @(posedge clk); #1;
        rst_n = 1'b1;
        checking = 1'b1;
    endtask

    // One bit slot: falling edge with new word select and data, then rising edge.
    task automatic send_slot(input logic w, input logic d);
        bclk = 1'b0; wsel = w; sdat = d;
        repeat (HALF) begin @(posedge clk); #1; end
        bclk = 1'b1;
        repeat (HALF) begin @(posedge clk); #1; end
    endtask

    function automatic logic [23:0] exp_word(input logic [1:0] f, input logic [31:0] wb);
        int w, s;
        if (f == 2'b00) return wb[31:8];
        w = 12 + 4 * int'(f);
        s = $signed(wb << (32 - w)) >>> (32 - w);
        return s[23:0];
    endfunction

    task automatic push_exp(input bit is_err, input logic [23:0] l, input logic [23:0] r, input string tag);
        exp_t e;
        e.cyc = cyc + HALF + LATENCY;
        e.is_err = is_err; e.l = l; e.r = r; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic run_stream(input logic [1:0] f, input int h, input int nfr, input string tag);
        logic [31:0] lw[8];
        logic [31:0] rw[8];
        logic [31:0] prev, cur, mask;
        logic        d;
        bit          sh;
        int          need;
        apply_reset(f);
        need = (f == 2'b00) ? 8 : 12 + 4 * int'(f);
        sh   = (h < need);
        mask = (f == 2'b00) ? (32'hFFFF_FFFF << (32 - h)) : 32'hFFFF_FFFF;
        for (int k = 0; k < nfr; k++) begin
            lw[k] = $urandom() & mask;
            rw[k] = $urandom() & mask;
        end
        prev = '0;
        for (int fi = 0; fi <= nfr; fi++) begin
            for (int hf = 0; hf < 2; hf++) begin
                if (fi == nfr && hf == 1) break;
                cur = (fi == nfr) ? 32'h0 : (hf == 1 ? rw[fi] : lw[fi]);
                for (int i = 0; i < h; i++) begin
                    if (fi == nfr && i > 0) break;
                    if (i == 0 && (fi > 0 || hf == 1)) begin
                        if (hf == 1) begin
                            if (fi >= 1 && sh) push_exp(1'b1, '0, '0, {tag, " R5 left short"});
                        end else begin
                            if (sh) push_exp(1'b1, '0, '0, {tag, " R5 right short"});
                            else if (fi - 1 >= 1)
                                push_exp(1'b0, exp_word(f, lw[fi-1]), exp_word(f, rw[fi-1]), tag);
                        end
                    end
                    if (f == 2'b00) d = (i == 0) ? prev[32 - h] : cur[32 - i];
                    else            d = cur[h - 1 - i];
                    send_slot(hf[0], d);
                end
                prev = cur;
            end
        end
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        run_stream(2'b00, 32, 4, "R1 R2 R4 i2s 32 slots, bits past 24 ignored");
        run_stream(2'b00, 16, 4, "R1 R2 R4 i2s 16 slots, zero padded");
        run_stream(2'b00, 24, 3, "R2 R4 R6 i2s 24 slots");
        run_stream(2'b00,  8, 3, "R2 R5 i2s 8 slots boundary");
        run_stream(2'b01, 32, 4, "R1 R3 R4 rj16 in 32 slots");
        run_stream(2'b01, 16, 4, "R3 R4 rj16 exact fit");
        run_stream(2'b10, 20, 4, "R1 R3 R4 rj20 exact fit");
        run_stream(2'b11, 32, 4, "R1 R3 R4 R6 rj24 in 32 slots");
        run_stream(2'b11, 16, 3, "R5 rj24 in 16 slots");
        run_stream(2'b00,  6, 3, "R5 i2s 6 slots");
        repeat (10) @(posedge clk);
        checking = 1'b0;
        if (expq.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R4 drain: actual %0d pending events expected 0", expq.size());
        end
        summary();
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual run still active after %0d cycles expected finish", WATCHDOG);
        summary();
        $finish;
    end

endmodule